// File: doc/BRIEF.md
# CEC Frame Receiver with Own-Address Acknowledge

This block listens to a single-wire consumer-electronics control bus. It measures every low pulse and every bit period in units of a 25 µs timing tick (40 kHz) and recognises the long start pulse. After that it decodes each following pulse as a logic 1 (short low) or a logic 0 (long low) and assembles the bits into bytes, most significant bit first. Each byte is followed by an end-of-message bit and an acknowledge slot. The low nibble of the first (header) byte names the destination. When it equals the configured own address, the receiver pulls the line low in every acknowledge slot of the frame.

Up to sixteen bytes are kept in a flat receive vector, and the first byte lands in the lowest eight bits. When the acknowledge slot of the byte that carries a set end-of-message bit completes, the block raises an end flag, a good flag and an interrupt. It then ignores the bus until software raises and lowers a clear input. A separate receive reset input holds the receiver idle.

Top module: `cec_rx`

## Requirements
- R1: A start pulse is accepted only when its low phase is 140 to 156 ticks (3500–3900 µs) and its whole period is 172 to 188 ticks (4300–4700 µs). Any other long pulse is ignored and gets neither an acknowledge nor an interrupt.
- R2: A data pulse decodes as 1 for a low time of 16–32 ticks (400–800 µs) and as 0 for 52–68 ticks (1300–1700 µs). Its period must be 82–110 ticks (2050–2750 µs). Any other low time or period aborts the frame, and no interrupt is raised.
- R3: Bits arrive most significant first. The header's low nibble (bits 3:0) is compared with `ownAddr`. On a mismatch the frame is dropped with no acknowledge and no interrupt.
- R4: In every acknowledge slot of a matched frame, `cecDriveLow` rises on the detected falling edge and stays high for 60 ticks (1500 µs), then releases. It is never high while `irq` is high.
- R5: Byte k of the frame, for k from 0 to 15, is stored in `rxData[8k+7:8k]`, with the header at bits 7:0. Bytes after the sixteenth are still acknowledged but are not stored, and the stored ones remain unchanged. Storage is cleared when a new frame starts.
- R6: `rxByteCount` equals the number of stored bytes minus one, which is 15 at most.
- R7: The ninth bit of each byte is the end-of-message bit, with 1 meaning the last byte. After the acknowledge slot of that byte, `rxEom`, `rxGood` and `irq` go high together.
- R8: While `irq` is high, bus activity is ignored: nothing is acknowledged and the stored data do not change. Raising `clearRx` drops `irq`, `rxEom` and `rxGood`. Lowering it re-arms reception.
- R9: While `rxSwReset` is high, the receiver stays idle, `cecDriveLow` is low, and the flags and `irq` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe every 25 µs |
| cecIn | input | 1 | Sensed bus level, 1 = released |
| ownAddr | input | 4 | Own logical address |
| clearRx | input | 1 | Clear and re-arm, used as a high-then-low pulse |
| rxSwReset | input | 1 | Holds the receiver in reset |
| cecDriveLow | output | 1 | 1 pulls the bus low |
| rxData | output | 128 | Received bytes, byte k at bits 8k+7:8k |
| rxByteCount | output | 4 | Stored bytes minus one |
| rxEom | output | 1 | Frame ended |
| rxGood | output | 1 | Frame received without error |
| irq | output | 1 | Receive interrupt |

## Verification
The bench samples the drive output in the middle and after the end of every acknowledge slot. A design that acknowledges other addresses, or releases the line early or late, therefore shows up directly. An eighteen-byte frame checks that the count saturates at 15 and that all sixteen stored bytes land in the right positions. A design that wraps the store index would overwrite the header. Short start pulses, low times that fall between the two bit windows, and frames sent while the interrupt is pending or while the reset is held must all pass without an acknowledge or an interrupt. A receiver that leaks through any of them raises `irq` or changes `rxData`.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int TIMER_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START_LOW, ST_START_HIGH, ST_BIT_LOW, ST_BIT_HIGH, ST_DONE, ST_CLEARING
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic frameStart;
    logic shiftEn;
    logic storeByte;
    logic bitVal;
  } dpStrobes_t;
endpackage

// File: rtl/cec_rx_datapath.sv
module cec_rx_datapath
  import cec_rx_pkg::*;
#(
  parameter int MAX_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobes_t                   strobes,
  output logic [7:0]                   assembled,
  output logic [MAX_BYTES*8-1:0]       rxData,
  output logic [$clog2(MAX_BYTES)-1:0] rxByteCount
);
  localparam int IDX_W = $clog2(MAX_BYTES);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_BYTES);

  logic [6:0]       shiftReg;
  logic [CNT_W-1:0] byteCnt;
  logic [7:0]       store [MAX_BYTES];

  assign assembled = {shiftReg, strobes.bitVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      byteCnt  <= '0;
      for (int i = 0; i < MAX_BYTES; i++) store[i] <= '0;
    end else if (strobes.frameStart) begin
      shiftReg <= '0;
      byteCnt  <= '0;
      for (int i = 0; i < MAX_BYTES; i++) store[i] <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= assembled[6:0];
      if (strobes.storeByte && byteCnt < FULL) begin
        store[byteCnt[IDX_W-1:0]] <= assembled;
        byteCnt <= byteCnt + CNT_W'(1);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < MAX_BYTES; g++) begin : g_pack
      assign rxData[g*8 +: 8] = store[g];
    end
  endgenerate

  always_comb begin
    if (byteCnt == '0) rxByteCount = '0;
    else               rxByteCount = IDX_W'(byteCnt - CNT_W'(1));
  end

  // R5: a byte arriving with storage full leaves the stored bytes alone
  a_r5_drop_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.storeByte && strobes.shiftEn && !strobes.frameStart && byteCnt == FULL)
      |=> $stable(rxData));
endmodule

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
  import cec_rx_pkg::*;
#(
  parameter int START_LOW_MIN = 140,
  parameter int START_LOW_MAX = 156,
  parameter int START_PER_MIN = 172,
  parameter int START_PER_MAX = 188,
  parameter int ONE_LOW_MIN   = 16,
  parameter int ONE_LOW_MAX   = 32,
  parameter int ZERO_LOW_MIN  = 52,
  parameter int ZERO_LOW_MAX  = 68,
  parameter int BIT_PER_MIN   = 82,
  parameter int BIT_PER_MAX   = 110,
  parameter int ACK_TICKS     = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       cecIn,
  input  logic [3:0] ownAddr,
  input  logic       clearRx,
  input  logic       rxSwReset,
  input  logic [7:0] assembled,
  output dpStrobes_t strobes,
  output logic       cecDriveLow,
  output logic       rxEom,
  output logic       rxGood,
  output logic       irq
);
  localparam logic [TIMER_W-1:0] ACK_LAST = TIMER_W'(ACK_TICKS - 1);

  rxState_t           state;
  logic [TIMER_W-1:0] timer;
  logic [3:0]         bitIdx;
  logic               isHeader, eomFlag;
  logic               syncA, syncB, linePrev;
  logic               fall, rise, bitOne, bitZero, bitOk, perOk, startPerOk, startLowOk;

  function automatic logic inRange(logic [TIMER_W-1:0] v, int lo, int hi);
    return (int'(v) >= lo) && (int'(v) <= hi);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1; syncB <= 1'b1; linePrev <= 1'b1;
    end else begin
      syncA <= cecIn; syncB <= syncA; linePrev <= syncB;
    end
  end

  assign fall       = linePrev && !syncB;
  assign rise       = !linePrev && syncB;
  assign bitOne     = inRange(timer, ONE_LOW_MIN, ONE_LOW_MAX);
  assign bitZero    = inRange(timer, ZERO_LOW_MIN, ZERO_LOW_MAX);
  assign bitOk      = bitOne || bitZero;
  assign perOk      = inRange(timer, BIT_PER_MIN, BIT_PER_MAX);
  assign startLowOk = inRange(timer, START_LOW_MIN, START_LOW_MAX);
  assign startPerOk = inRange(timer, START_PER_MIN, START_PER_MAX);

  always_comb begin
    strobes.frameStart = (state == ST_START_HIGH) && fall && startPerOk;
    strobes.shiftEn    = (state == ST_BIT_LOW) && rise && bitOk && (bitIdx < 4'd8);
    strobes.storeByte  = (bitIdx == 4'd7);
    strobes.bitVal     = bitOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; timer <= '0; bitIdx <= '0; isHeader <= 1'b0; eomFlag <= 1'b0;
      cecDriveLow <= 1'b0; rxEom <= 1'b0; rxGood <= 1'b0; irq <= 1'b0;
    end else if (rxSwReset) begin
      state <= ST_IDLE; bitIdx <= '0; isHeader <= 1'b0; eomFlag <= 1'b0;
      cecDriveLow <= 1'b0; rxEom <= 1'b0; rxGood <= 1'b0; irq <= 1'b0;
    end else begin
      if (tick && timer != '1) timer <= timer + TIMER_W'(1);
      if (cecDriveLow && tick && timer >= ACK_LAST) cecDriveLow <= 1'b0;
      case (state)
        ST_IDLE:
          if (fall) begin timer <= '0; state <= ST_START_LOW; end
        ST_START_LOW:
          if (rise) state <= startLowOk ? ST_START_HIGH : ST_IDLE;
        ST_START_HIGH:
          if (fall) begin
            if (startPerOk) begin
              timer <= '0; bitIdx <= '0; isHeader <= 1'b1; eomFlag <= 1'b0;
              state <= ST_BIT_LOW;
            end else state <= ST_IDLE;
          end else if (int'(timer) > START_PER_MAX) state <= ST_IDLE;
        ST_BIT_LOW:
          if (rise) begin
            if (!bitOk) state <= ST_IDLE;
            else begin
              if (bitIdx == 4'd8) eomFlag <= bitOne;
              if (bitIdx == 4'd7 && isHeader && assembled[3:0] != ownAddr) state <= ST_IDLE;
              else if (bitIdx == 4'd9 && eomFlag) begin
                state <= ST_DONE; rxEom <= 1'b1; rxGood <= 1'b1; irq <= 1'b1;
              end else state <= ST_BIT_HIGH;
            end
          end
        ST_BIT_HIGH:
          if (fall) begin
            if (perOk) begin
              timer <= '0; state <= ST_BIT_LOW;
              if (bitIdx == 4'd9) begin bitIdx <= '0; isHeader <= 1'b0; end
              else bitIdx <= bitIdx + 4'd1;
              if (bitIdx == 4'd8) cecDriveLow <= 1'b1;
            end else state <= ST_IDLE;
          end else if (int'(timer) > BIT_PER_MAX) state <= ST_IDLE;
        ST_DONE:
          if (clearRx) begin
            rxEom <= 1'b0; rxGood <= 1'b0; irq <= 1'b0; state <= ST_CLEARING;
          end
        ST_CLEARING:
          if (!clearRx) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: receive reset releases the line and drops the interrupt
  a_r9_swreset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    rxSwReset |=> (!cecDriveLow && !irq && !rxEom));
  // R8: interrupt stays pending until software clears it
  a_r8_irq_held: assert property (@(posedge clk) disable iff (!rstN || rxSwReset)
    (irq && !clearRx) |=> irq);
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rstN || rxSwReset)
    (irq && clearRx) |=> !irq);
  // R4: acknowledge drive is finished before the interrupt and bounded in length
  a_r4_no_drive_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !cecDriveLow);
  a_r4_drive_bounded: assert property (@(posedge clk) disable iff (!rstN)
    cecDriveLow |-> (int'(timer) < ACK_TICKS));
endmodule

// File: rtl/cec_rx.sv
module cec_rx
  import cec_rx_pkg::*;
#(
  parameter int MAX_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick,
  input  logic                         cecIn,
  input  logic [3:0]                   ownAddr,
  input  logic                         clearRx,
  input  logic                         rxSwReset,
  output logic                         cecDriveLow,
  output logic [MAX_BYTES*8-1:0]       rxData,
  output logic [$clog2(MAX_BYTES)-1:0] rxByteCount,
  output logic                         rxEom,
  output logic                         rxGood,
  output logic                         irq
);
  dpStrobes_t strobes;
  logic [7:0] assembled;

  cec_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cecIn(cecIn), .ownAddr(ownAddr),
    .clearRx(clearRx), .rxSwReset(rxSwReset), .assembled(assembled),
    .strobes(strobes), .cecDriveLow(cecDriveLow), .rxEom(rxEom),
    .rxGood(rxGood), .irq(irq)
  );

  cec_rx_datapath #(.MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .assembled(assembled),
    .rxData(rxData), .rxByteCount(rxByteCount)
  );
endmodule

// File: tb/cec_rx_bench.sv
module cec_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ONE_LOW = 24, ZERO_LOW = 60, BIT_PER = 96;

  logic clk = 0, rstN = 0, benchLow = 0, clearRx = 0, rxSwReset = 0;
  logic [3:0] ownAddr = 4'h4;
  logic cecDriveLow, rxEom, rxGood, irq;
  logic [127:0] rxData;
  logic [3:0] rxByteCount;
  logic cecIn;
  logic [7:0] frm [0:17];
  int checks = 0, errors = 0;

  assign cecIn = !(benchLow || cecDriveLow);
  always #(CLK_PERIOD/2) clk = ~clk;

  cec_rx u_cec_rx (
    .clk(clk), .rstN(rstN), .tick(1'b1), .cecIn(cecIn), .ownAddr(ownAddr),
    .clearRx(clearRx), .rxSwReset(rxSwReset), .cecDriveLow(cecDriveLow),
    .rxData(rxData), .rxByteCount(rxByteCount), .rxEom(rxEom),
    .rxGood(rxGood), .irq(irq)
  );

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPulse(input int lowT, input int perT);
    benchLow = 1; waitN(lowT);
    benchLow = 0; waitN(perT - lowT);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic last, input logic expAck);
    for (int i = 7; i >= 0; i--) sendPulse(b[i] ? ONE_LOW : ZERO_LOW, BIT_PER);
    sendPulse(last ? ONE_LOW : ZERO_LOW, BIT_PER);
    benchLow = 1; waitN(ONE_LOW); benchLow = 0;
    waitN(50 - ONE_LOW);
    check(cecDriveLow == expAck, "R4 ack drive mid-slot", cecDriveLow, expAck);
    waitN(20);
    check(cecDriveLow == 0, "R4 ack released after 1500us", cecDriveLow, 0);
    waitN(BIT_PER - 70);
  endtask

  task automatic sendFrame(input int n, input int startLow, input logic expAck);
    sendPulse(startLow, 180);
    for (int i = 0; i < n; i++) sendByte(frm[i], i == n - 1, expAck);
    waitN(20);
  endtask

  task automatic clearIrq();
    clearRx = 1; waitN(3);
    check(irq == 0 && rxEom == 0 && rxGood == 0, "R8 clear drops flags", {irq, rxEom, rxGood}, 0);
    clearRx = 0; waitN(3);
  endtask

  task automatic testReset();
    check(irq == 0 && cecDriveLow == 0 && rxEom == 0, "R9 reset state", {irq, cecDriveLow, rxEom}, 0);
    check(rxByteCount == 0 && rxData == 0, "R6 reset count", rxByteCount, 0);
  endtask

  task automatic testShortFrame();
    frm[0] = 8'h14; frm[1] = 8'h36;
    sendFrame(2, 148, 1);
    check(irq && rxEom && rxGood, "R7 end flags", {irq, rxEom, rxGood}, 3'b111);
    check(rxByteCount == 4'd1, "R6 count two bytes", rxByteCount, 1);
    check(rxData == 128'h3614, "R5 R3 packing msb-first", rxData, 128'h3614);
  endtask

  task automatic testLockout();
    frm[0] = 8'h24; frm[1] = 8'hAA; frm[2] = 8'h55;
    sendFrame(3, 148, 0);
    check(irq == 1, "R8 irq held while locked", irq, 1);
    check(rxData == 128'h3614, "R8 data untouched while locked", rxData, 128'h3614);
    clearIrq();
    frm[0] = 8'h24; frm[1] = 8'h5A;
    sendFrame(2, 148, 1);
    check(irq == 1 && rxData == 128'h5A24, "R8 re-armed after clear", rxData, 128'h5A24);
    clearIrq();
  endtask

  task automatic testMismatch();
    frm[0] = 8'h45; frm[1] = 8'h11;
    sendFrame(2, 148, 0);
    check(irq == 0, "R3 other destination no irq", irq, 0);
  endtask

  task automatic testBadStart();
    frm[0] = 8'h04; frm[1] = 8'h77;
    sendFrame(2, 120, 0);
    check(irq == 0, "R1 short start ignored", irq, 0);
  endtask

  task automatic testBadBit();
    sendPulse(148, 180);
    sendPulse(ONE_LOW, BIT_PER);
    sendPulse(45, BIT_PER);
    for (int i = 0; i < 6; i++) sendPulse(ZERO_LOW, BIT_PER);
    sendPulse(ONE_LOW, BIT_PER);
    waitN(60);
    check(cecDriveLow == 0, "R2 bad low time no ack", cecDriveLow, 0);
    check(irq == 0, "R2 bad low time no irq", irq, 0);
    sendPulse(148, 180);
    sendPulse(ONE_LOW, 150);
    waitN(200);
    check(irq == 0, "R2 long period aborts", irq, 0);
  endtask

  task automatic testLongFrame();
    logic [127:0] exp;
    frm[0] = 8'h34;
    for (int i = 1; i < 18; i++) frm[i] = 8'(i * 17 + 3);
    exp = '0;
    for (int i = 0; i < 16; i++) exp[i*8 +: 8] = frm[i];
    sendFrame(18, 148, 1);
    check(irq == 1, "R7 long frame irq", irq, 1);
    check(rxByteCount == 4'd15, "R6 count saturates", rxByteCount, 15);
    check(rxData == exp, "R5 first sixteen stored", rxData, exp);
  endtask

  task automatic testSwReset();
    rxSwReset = 1; waitN(2);
    check(irq == 0 && rxEom == 0 && rxGood == 0, "R9 swreset clears flags", {irq, rxEom, rxGood}, 0);
    frm[0] = 8'h04; frm[1] = 8'h99;
    sendFrame(2, 148, 0);
    check(irq == 0, "R9 no reception in reset", irq, 0);
    rxSwReset = 0; waitN(5);
    sendFrame(2, 148, 1);
    check(irq == 1 && rxData == 128'h9904, "R9 receives after release", rxData, 128'h9904);
    clearIrq();
  endtask

  initial begin
    waitN(3); rstN = 1; waitN(3);
    testReset();
    testShortFrame();
    testLockout();
    testMismatch();
    testBadStart();
    testBadBit();
    testLongFrame();
    clearIrq();
    testSwReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule